// File: doc/BRIEF.md
# Time Base and Watchdog Interrupt Generator

This block divides a low-rate clock-enable tick (one pulse per cycle of a 32.768 kHz source) into two services that share a single counter chain: a periodic square wave whose frequency is chosen by a 3-bit rate code, and a watchdog that raises a sticky time-out flag after a fixed number of periods of that square wave. The lower eight bits of the chain form a divide-by-256 prescaler. The upper seven bits extend it down to 1 Hz.

A command decoder drives single-cycle strobes into the block. There is an on, off and clear strobe for the timer and for the watchdog, an on and off strobe for the interrupt, and a load strobe for the rate code. A system-enable level gates the whole divider. The block combines the square wave and the watchdog flag into one active-low interrupt line, which is meant for an open-drain pad. Each enable is independent of the others. A pending watchdog time-out keeps the line low until software clears the watchdog or switches the interrupt off.

Top module: `tbw_timebase_wdt`

## Requirements
- R1: After reset `irq_n` is 1, `tb_clk` is 0, `wdt_flag` is 0, the timer, watchdog and interrupt enables are off, and the rate code is 7.
- R2: With the divider cleared, rate code k gives a `tb_clk` square wave with a period of 2^(15-k) ticks. It goes high after 2^(14-k) ticks: 128 Hz for code 7 down to 1 Hz for code 0.
- R3: The divider advances only in cycles where `tick` is 1 and `sys_en` is 1. Cycles without a tick leave `tb_clk` unchanged.
- R4: While the watchdog is enabled, `wdt_flag` rises on the fourth end of a `tb_clk` period after a watchdog clear, in the cycle after that tick. With the divider cleared at the same time, that is 4*2^(15-k) ticks: 1/32 s for code 7, up to 4 s for code 0.
- R5: Once set, `wdt_flag` stays 1 until `wdt_clr` or `irq_off` is seen. A clear or an interrupt-off in the same cycle as the period end that would set the flag leaves it at 0.
- R6: `tmr_clr` returns the divider to zero, and this wins over a tick in the same cycle. `wdt_clr` clears only the watchdog count and the flag.
- R7: `irq_n` is 0 exactly when the interrupt is enabled and either `wdt_flag` is 1, or the timer is enabled and `tb_clk` is 0. Otherwise `irq_n` is 1.
- R8: Each enable changes only in response to its own strobes. When on and off strobes arrive in the same cycle, off wins.
- R9: While `sys_en` is 0, the divider, the watchdog count and the flag are held at zero. The enables and the rate code keep their values.
- R10: `rate_wr` loads `rate_code` into the rate register. The new code takes effect in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable, one pulse per source period |
| sys_en | input | 1 | Run level for the divider and watchdog |
| tmr_on | input | 1 | Strobe: enable time base onto interrupt |
| tmr_off | input | 1 | Strobe: disable time base onto interrupt |
| tmr_clr | input | 1 | Strobe: clear the divider chain |
| wdt_on | input | 1 | Strobe: enable watchdog counting |
| wdt_off | input | 1 | Strobe: disable watchdog counting |
| wdt_clr | input | 1 | Strobe: clear watchdog count and flag |
| irq_on | input | 1 | Strobe: enable interrupt output |
| irq_off | input | 1 | Strobe: disable interrupt output, clear flag |
| rate_wr | input | 1 | Strobe: load rate code |
| rate_code | input | 3 | Rate code, 0 = 1 Hz ... 7 = 128 Hz |
| tb_clk | output | 1 | Selected time-base square wave |
| wdt_flag | output | 1 | Sticky watchdog time-out flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The watchdog's fourth period end can land in the same cycle as a watchdog clear or an interrupt-off command. The stimulus clears the divider and the watchdog together, counts ticks up to the exact timing cycle, and issues the clear or interrupt-off strobe together with that tick. The flag must then stay 0. In the case of the clear, it must then rise only after a further four full periods. A behavioural model compares both outcomes every cycle, and directed checks confirm them.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

   typedef struct packed {
      logic on;
      logic off;
   } tbw_onoff_t;

   // off dominates on; otherwise hold
   function automatic logic tbw_next_en(input logic cur, input tbw_onoff_t c);
      if (c.off)
         return 1'b0;
      else if (c.on)
         return 1'b1;
      return cur;
   endfunction

endpackage

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
   import tbw_pkg::*;
#(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned RATE_RST = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tbw_onoff_t       tmr_cmd,
   input  tbw_onoff_t       wdt_cmd,
   input  tbw_onoff_t       irq_cmd,
   input  logic             rate_wr,
   input  logic [SEL_W-1:0] rate_code,
   output logic             tmr_en_q,
   output logic             wdt_en_q,
   output logic             irq_en_q,
   output logic [SEL_W-1:0] rate_q
);

   localparam logic [SEL_W-1:0] RATE_INIT = SEL_W'(RATE_RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_en_q <= 1'b0;
         wdt_en_q <= 1'b0;
         irq_en_q <= 1'b0;
         rate_q   <= RATE_INIT;
      end else begin
         tmr_en_q <= tbw_next_en(tmr_en_q, tmr_cmd);
         wdt_en_q <= tbw_next_en(wdt_en_q, wdt_cmd);
         irq_en_q <= tbw_next_en(irq_en_q, irq_cmd);
         if (rate_wr)
            rate_q <= rate_code;
      end
   end

endmodule

// File: rtl/tbw_divider.sv
module tbw_divider #(
   parameter int unsigned PRE_W   = 8,
   parameter int unsigned CHAIN_W = 7,
   parameter int unsigned SEL_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             sys_en,
   input  logic             clr,
   input  logic [SEL_W-1:0] rate_q,
   output logic             tb_clk,
   output logic             period_end
);

   localparam int unsigned TOT_W = PRE_W + CHAIN_W;
   localparam int unsigned NCODE = CHAIN_W + 1;

   logic [TOT_W-1:0] cnt_q;
   logic [NCODE-1:0] wave_v;
   logic [NCODE-1:0] wrap_v;
   logic             advance;

   assign advance = sys_en & tick & ~clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!sys_en || clr)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_q + 1'b1;
   end

   // code g taps bit TOT_W-1-g: code 0 slowest, code CHAIN_W is the prescaler MSB
   for (genvar g = 0; g < NCODE; g++) begin : g_tap
      assign wave_v[g] = cnt_q[TOT_W-1-g];
      assign wrap_v[g] = &cnt_q[TOT_W-1-g:0];
   end

   assign tb_clk     = wave_v[rate_q];
   assign period_end = advance & wrap_v[rate_q];

endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog #(
   parameter int unsigned WDT_PERIODS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sys_en,
   input  logic wdt_en_q,
   input  logic wdt_clr,
   input  logic irq_off,
   input  logic period_end,
   output logic wdt_flag
);

   logic flag_q;
   logic hit;

   if (WDT_PERIODS == 1) begin : g_direct
      assign hit = wdt_en_q & period_end;
   end else begin : g_count
      localparam int unsigned WC_W = $clog2(WDT_PERIODS);
      localparam logic [WC_W-1:0] LAST = WC_W'(WDT_PERIODS - 1);
      logic [WC_W-1:0] wc_q;

      assign hit = wdt_en_q & period_end & (wc_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            wc_q <= '0;
         else if (!sys_en || wdt_clr)
            wc_q <= '0;
         else if (hit)
            wc_q <= '0;
         else if (wdt_en_q && period_end)
            wc_q <= wc_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (!sys_en || wdt_clr || irq_off)
         flag_q <= 1'b0;
      else if (hit)
         flag_q <= 1'b1;
   end

   assign wdt_flag = flag_q;

endmodule

// File: rtl/tbw_timebase_wdt.sv
module tbw_timebase_wdt
   import tbw_pkg::*;
#(
   parameter int unsigned PRE_W       = 8,
   parameter int unsigned CHAIN_W     = 7,
   parameter int unsigned WDT_PERIODS = 4,
   parameter int unsigned SEL_W       = $clog2(CHAIN_W + 1),
   parameter int unsigned RATE_RST    = CHAIN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             sys_en,
   input  logic             tmr_on,
   input  logic             tmr_off,
   input  logic             tmr_clr,
   input  logic             wdt_on,
   input  logic             wdt_off,
   input  logic             wdt_clr,
   input  logic             irq_on,
   input  logic             irq_off,
   input  logic             rate_wr,
   input  logic [SEL_W-1:0] rate_code,
   output logic             tb_clk,
   output logic             wdt_flag,
   output logic             irq_n
);

   if (PRE_W < 1) begin : g_bad_pre
      $error("PRE_W must be at least 1");
   end
   if ((1 << SEL_W) != CHAIN_W + 1) begin : g_bad_sel
      $error("CHAIN_W+1 must equal 2**SEL_W");
   end
   if (WDT_PERIODS < 1) begin : g_bad_wdt
      $error("WDT_PERIODS must be at least 1");
   end
   if (RATE_RST > CHAIN_W) begin : g_bad_rst
      $error("RATE_RST out of range");
   end

   logic             tmr_en_q;
   logic             wdt_en_q;
   logic             irq_en_q;
   logic [SEL_W-1:0] rate_q;
   logic             period_end;
   tbw_onoff_t       tmr_cmd, wdt_cmd, irq_cmd;

   assign tmr_cmd = '{on: tmr_on, off: tmr_off};
   assign wdt_cmd = '{on: wdt_on, off: wdt_off};
   assign irq_cmd = '{on: irq_on, off: irq_off};

   tbw_ctrl #(
      .SEL_W   (SEL_W),
      .RATE_RST(RATE_RST)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .tmr_cmd  (tmr_cmd),
      .wdt_cmd  (wdt_cmd),
      .irq_cmd  (irq_cmd),
      .rate_wr  (rate_wr),
      .rate_code(rate_code),
      .tmr_en_q (tmr_en_q),
      .wdt_en_q (wdt_en_q),
      .irq_en_q (irq_en_q),
      .rate_q   (rate_q)
   );

   tbw_divider #(
      .PRE_W  (PRE_W),
      .CHAIN_W(CHAIN_W),
      .SEL_W  (SEL_W)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .sys_en    (sys_en),
      .clr       (tmr_clr),
      .rate_q    (rate_q),
      .tb_clk    (tb_clk),
      .period_end(period_end)
   );

   tbw_watchdog #(
      .WDT_PERIODS(WDT_PERIODS)
   ) u_wdt (
      .clk       (clk),
      .rst_n     (rst_n),
      .sys_en    (sys_en),
      .wdt_en_q  (wdt_en_q),
      .wdt_clr   (wdt_clr),
      .irq_off   (irq_off),
      .period_end(period_end),
      .wdt_flag  (wdt_flag)
   );

   // pull low on a pending time-out, or on the low phase of an enabled time base
   assign irq_n = ~(irq_en_q & (wdt_flag | (tmr_en_q & ~tb_clk)));

endmodule

// File: rtl/tbw_checker.sv
module tbw_checker (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic sys_en,
   input logic tmr_on,
   input logic tmr_off,
   input logic tmr_clr,
   input logic wdt_clr,
   input logic irq_off,
   input logic rate_wr,
   input logic tb_clk,
   input logic wdt_flag,
   input logic irq_n,
   input logic tmr_en_q,
   input logic wdt_en_q,
   input logic irq_en_q,
   input logic period_end
);

   p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_flag && sys_en && !wdt_clr && !irq_off) |=> wdt_flag);

   p_clr_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_clr || irq_off) |=> !wdt_flag);

   p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_flag) |-> ($past(wdt_en_q) && $past(period_end)));

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_en |=> (!tb_clk && !wdt_flag));

   p_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && sys_en && !tmr_clr && !rate_wr) |=> $stable(tb_clk));

   p_tclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_clr |=> !tb_clk);

   p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_off |=> irq_n);

   p_flag_pull_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_flag && irq_en_q) |-> !irq_n);

   p_off_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_on && tmr_off) |=> !tmr_en_q);

endmodule

bind tbw_timebase_wdt tbw_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .sys_en    (sys_en),
   .tmr_on    (tmr_on),
   .tmr_off   (tmr_off),
   .tmr_clr   (tmr_clr),
   .wdt_clr   (wdt_clr),
   .irq_off   (irq_off),
   .rate_wr   (rate_wr),
   .tb_clk    (tb_clk),
   .wdt_flag  (wdt_flag),
   .irq_n     (irq_n),
   .tmr_en_q  (tmr_en_q),
   .wdt_en_q  (wdt_en_q),
   .irq_en_q  (irq_en_q),
   .period_end(period_end)
);

// File: tb/tbw_timebase_wdt_bench.sv
`timescale 1ns/1ps
module tbw_timebase_wdt_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, sys_en = 1'b0;
   logic tmr_on = 0, tmr_off = 0, tmr_clr = 0;
   logic wdt_on = 0, wdt_off = 0, wdt_clr = 0;
   logic irq_on = 0, irq_off = 0, rate_wr = 0;
   logic [2:0] rate_code = 3'd0;
   logic tb_clk, wdt_flag, irq_n;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   tbw_timebase_wdt u_tbw_timebase_wdt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sys_en(sys_en),
      .tmr_on(tmr_on), .tmr_off(tmr_off), .tmr_clr(tmr_clr),
      .wdt_on(wdt_on), .wdt_off(wdt_off), .wdt_clr(wdt_clr),
      .irq_on(irq_on), .irq_off(irq_off), .rate_wr(rate_wr),
      .rate_code(rate_code), .tb_clk(tb_clk), .wdt_flag(wdt_flag),
      .irq_n(irq_n)
   );

   // behavioural reference model
   int m_cnt, m_wc, m_rate;
   bit m_flag, m_tmr, m_wdt, m_irq;

   always @(posedge clk or negedge rst_n) begin
      int span;
      bit pe;
      if (!rst_n) begin
         m_cnt = 0; m_wc = 0; m_rate = 7;
         m_flag = 0; m_tmr = 0; m_wdt = 0; m_irq = 0;
      end else begin
         span = 1 << (15 - m_rate);
         pe = sys_en && tick && !tmr_clr && (((m_cnt + 1) % span) == 0);
         if (!sys_en || tmr_clr) m_cnt = 0;
         else if (tick) m_cnt = (m_cnt + 1) % 32768;
         if (!sys_en || wdt_clr) begin
            m_wc = 0; m_flag = 0;
         end else begin
            if (m_wdt && pe) begin
               if (m_wc == 3) begin m_flag = 1; m_wc = 0; end
               else m_wc = m_wc + 1;
            end
            if (irq_off) m_flag = 0;
         end
         if (tmr_off) m_tmr = 0; else if (tmr_on) m_tmr = 1;
         if (wdt_off) m_wdt = 0; else if (wdt_on) m_wdt = 1;
         if (irq_off) m_irq = 0; else if (irq_on) m_irq = 1;
         if (rate_wr) m_rate = int'(rate_code);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      bit m_tb;
      cycles++;
      if (rst_n) begin
         m_tb = ((m_cnt >> (14 - m_rate)) & 1) != 0;
         check("R2 model tb_clk", int'(tb_clk), int'(m_tb));
         check("R4 model wdt_flag", int'(wdt_flag), int'(m_flag));
         check("R7 model irq_n", int'(irq_n),
               int'(!(m_irq && (m_flag || (m_tmr && !m_tb)))));
      end
   end

   task automatic clr_cmds();
      tmr_on = 0; tmr_off = 0; tmr_clr = 0;
      wdt_on = 0; wdt_off = 0; wdt_clr = 0;
      irq_on = 0; irq_off = 0; rate_wr = 0;
   endtask

   task automatic run(input int n, input logic t);
      for (int i = 0; i < n; i++) begin
         tick = t;
         @(negedge clk);
      end
      tick = 0;
      clr_cmds();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      check("R1 irq_n", int'(irq_n), 1);
      check("R1 tb_clk", int'(tb_clk), 0);
      check("R1 wdt_flag", int'(wdt_flag), 0);

      sys_en = 1;
      irq_on = 1; tmr_on = 1; tmr_clr = 1;
      run(1, 0);
      check("R7 low phase pulls irq", int'(irq_n), 0);
      // R1/R2 default code 7: high after 128 ticks
      run(127, 1);
      check("R2 code7 before half", int'(tb_clk), 0);
      run(1, 1);
      check("R2 code7 at half", int'(tb_clk), 1);
      check("R7 high phase releases", int'(irq_n), 1);

      // R3 no advance without tick, then alternate
      run(50, 0);
      check("R3 held without tick", int'(tb_clk), 1);
      for (int i = 0; i < 127; i++) begin run(1, 1); run(1, 0); end
      check("R3 127 sparse ticks", int'(tb_clk), 1);
      run(1, 1);
      check("R3 128th sparse tick", int'(tb_clk), 0);

      // R10 load code 3, R6 clear: high after 2048 ticks
      rate_wr = 1; rate_code = 3'd3; tmr_clr = 1;
      run(1, 1);
      check("R6 clear beats tick", int'(tb_clk), 0);
      run(2047, 1);
      check("R10 code3 before half", int'(tb_clk), 0);
      run(1, 1);
      check("R10 code3 at half", int'(tb_clk), 1);

      // R8 off wins over on; irq enable unaffected
      tmr_on = 1; tmr_off = 1; tmr_clr = 1;
      run(1, 0);
      check("R8 timer off wins", int'(irq_n), 1);

      // R4/R5 coincidence of time-out and watchdog clear at code 7
      rate_wr = 1; rate_code = 3'd7; wdt_on = 1; wdt_clr = 1; tmr_clr = 1;
      run(1, 0);
      run(1023, 1);
      check("R4 no flag before fourth period", int'(wdt_flag), 0);
      wdt_clr = 1;
      run(1, 1);
      check("R5 clear wins over timeout", int'(wdt_flag), 0);
      run(1023, 1);
      check("R4 flag after 1023 ticks", int'(wdt_flag), 0);
      run(1, 1);
      check("R4 flag after 1024 ticks", int'(wdt_flag), 1);
      check("R7 flag pulls irq", int'(irq_n), 0);
      run(300, 0);
      check("R5 flag held", int'(wdt_flag), 1);
      irq_off = 1;
      run(1, 0);
      check("R5 irq_off clears flag", int'(wdt_flag), 0);
      check("R7 irq disabled", int'(irq_n), 1);
      irq_on = 1;
      run(1, 0);
      check("R5 flag stays clear", int'(wdt_flag), 0);

      // R5 interrupt-off coinciding with time-out
      wdt_clr = 1; tmr_clr = 1;
      run(1, 0);
      run(1023, 1);
      irq_off = 1;
      run(1, 1);
      check("R5 irq_off wins over timeout", int'(wdt_flag), 0);
      irq_on = 1;
      run(1, 0);

      // R9 system disable holds divider and flag
      run(200, 1);
      check("R9 precondition tb high", int'(tb_clk), 1);
      sys_en = 0;
      run(300, 1);
      check("R9 tb held low", int'(tb_clk), 0);
      check("R9 flag held low", int'(wdt_flag), 0);
      sys_en = 1;
      run(128, 1);
      check("R9 resumes from zero", int'(tb_clk), 1);

      // R4 code 5: 4096 ticks
      rate_wr = 1; rate_code = 3'd5; wdt_clr = 1; tmr_clr = 1;
      run(1, 0);
      run(4095, 1);
      check("R4 code5 before timeout", int'(wdt_flag), 0);
      run(1, 1);
      check("R4 code5 timeout", int'(wdt_flag), 1);

      // R8 watchdog off wins; no further time-out
      wdt_on = 1; wdt_off = 1; wdt_clr = 1; tmr_clr = 1;
      run(1, 0);
      run(4200, 1);
      check("R8 watchdog off wins", int'(wdt_flag), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule